// File: doc/BRIEF.md
# Data-Object Mailbox Register Block

This block is the device side of a data-object mailbox. Host software reaches it through a 32-bit register port with four word addresses: control, status, write mailbox and read mailbox. A request object is sent by writing its dwords one at a time into the write mailbox. A go command then hands the object to a built-in responder. The responder waits a fixed number of cycles and returns the request unchanged as the response, so the block can be exercised on its own.

When the response is ready, the whole object can be read. Software reads the current response dword from the read mailbox and writes any value to that register to move to the next dword. Dword 1 of every object is a header word whose bits [15:0] give the total object length in dwords, header included.

A sticky interrupt-status bit records completion and error events, and an enable bit gates it onto the interrupt pin. An abort command and an asynchronous function-reset input both cancel a transfer in progress, including one that has been only partly read.

Top module: `dobj_mailbox`

## Requirements
- R1: After reset, the status register reads zero, the control register reads zero, the read mailbox reads zero, and `irq_o` is low.
- R2: A control write with bit 31 (go) set, made while the block is idle with at least 2 dwords buffered, sets Busy (status bit 0) at the next edge. Busy stays set for exactly LAT cycles. Busy then clears, and Data Object Ready (status bit 31) sets on the same edge.
- R3: While Ready is set, the read mailbox (address 3) shows the response dwords in the order they were written. Each write to address 3 moves to the next dword. The write that consumes the last dword clears Ready.
- R4: While Ready is clear, the read mailbox reads zero, and writes to it have no effect on the read position.
- R5: A write mailbox (address 2) write sets Error (status bit 2) and is dropped in either of two cases. The first case is when it would exceed the length in bits [15:0] of buffered dword 1. The second case is when the buffer already holds DEPTH dwords.
- R6: A write mailbox write while Busy or Ready is set sets Error and does not change the buffered object.
- R7: A go command while Busy or Ready is set, or with fewer than 2 dwords buffered, sets Error and does not set Busy.
- R8: Interrupt Status (status bit 1) sets when a response completes and when Error rises. It is cleared only by writing 1 to status bit 1. If a set event and a clear arrive in the same cycle, the set wins.
- R9: Control bit 1 is a readable interrupt enable. `irq_o` is high exactly when Interrupt Status and the enable are both set.
- R10: A control write with bit 0 (abort) set clears Busy, Ready, Error and both buffer indices at that edge. Abort leaves Interrupt Status unchanged and overrides a go in the same write.
- R11: Driving `func_rst_ni` low asynchronously clears Busy, Ready, Error and both indices. It keeps Interrupt Status and the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the whole block |
| func_rst_ni | input | 1 | Asynchronous active-low function reset; aborts the transfer |
| addr_i | input | 2 | Register word address: 0 control, 1 status, 2 write mailbox, 3 read mailbox |
| we_i | input | 1 | Write strobe for this cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after the following corner cases:
- **Truncated reads.** An abort or function reset lands between read-mailbox pops. A design that left Ready set or kept the read index would return stale dwords afterwards, and the next object would come back shifted.
- **Overflow.** The bench writes past the header length and past DEPTH. A design that stored the extra dword would echo it in the response.
- **Traffic while Busy.** The bench writes and issues go while the responder is Busy. Writes that were not dropped would corrupt the echoed object.
- **Interrupt bookkeeping.** The bench checks that abort and function reset leave Interrupt Status and the enable alone, that only a 1 written to bit 1 clears it, and that abort with go in the same write leaves the write index at zero. A go issued right after that is then expected to fail with Error.

// File: rtl/dobj_pkg.sv
package dobj_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STS  = 2'd1;
  localparam logic [1:0] A_WMB  = 2'd2;
  localparam logic [1:0] A_RMB  = 2'd3;

  localparam int CTL_ABORT = 0;
  localparam int CTL_IEN   = 1;
  localparam int CTL_GO    = 31;

  localparam int ST_BUSY = 0;
  localparam int ST_INT  = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_RDY  = 31;

  localparam int LEN_W = 16;
endpackage

// File: rtl/dobj_store.sv
module dobj_store #(
  parameter int DEPTH = 16,
  parameter int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [31:0]      wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [31:0]      rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [31:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == IDX_W'(g))) mem[g] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i[AW-1:0]];
endmodule

// File: rtl/dobj_responder.sv
module dobj_responder #(
  parameter int LAT   = 4,
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             kill_i,
  input  logic [IDX_W-1:0] count_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] count_o
);
  localparam int CW = $clog2(LAT + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [IDX_W-1:0] count_q;

  assign done_o  = busy_q && (cnt_q == '0) && !kill_i;
  assign busy_o  = busy_q;
  assign count_o = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      count_q <= '0;
    end else if (kill_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      cnt_q   <= CW'(LAT - 1);
      count_q <= count_i;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dobj_irq.sv
module dobj_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sts_o <= 1'b0;
    else if (set_i) sts_o <= 1'b1;
    else if (clr_i) sts_o <= 1'b0;
  end
endmodule

// File: rtl/dobj_mailbox.sv
module dobj_mailbox
  import dobj_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LAT   = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        func_rst_ni,
  input  logic [1:0]  addr_i,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  localparam int IDX_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_TWO = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(DEPTH);

  // transfer state sees both resets; interrupt state only the block reset
  logic trst_n;
  assign trst_n = rst_ni & func_rst_ni;

  logic             busy, done, ready_q, err_q, int_en_q, int_sts;
  logic [IDX_W-1:0] wr_idx_q, rd_idx_q, rsp_len_q, rsp_cnt;
  logic [LEN_W-1:0] hdr_len_q;
  logic [31:0]      buf_rdata;

  logic wr_ctrl, abort, go, wmb_wr, rmb_wr, sts_wr;
  logic wmb_bad, wmb_ok, go_bad, start, err_hit, err_set, pop, last_pop;

  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign abort   = wr_ctrl && wdata_i[CTL_ABORT];
  assign go      = wr_ctrl && wdata_i[CTL_GO] && !abort;
  assign wmb_wr  = we_i && (addr_i == A_WMB);
  assign rmb_wr  = we_i && (addr_i == A_RMB);
  assign sts_wr  = we_i && (addr_i == A_STS);

  assign wmb_bad = busy || ready_q || (wr_idx_q == IDX_MAX) ||
                   ((wr_idx_q >= IDX_TWO) && (32'(wr_idx_q) >= 32'(hdr_len_q)));
  assign wmb_ok  = wmb_wr && !wmb_bad;
  assign go_bad  = go && (busy || ready_q || (wr_idx_q < IDX_TWO));
  assign start   = go && !go_bad;
  assign err_hit = (wmb_wr && wmb_bad) || go_bad;
  assign err_set = err_hit && !err_q;
  assign pop      = rmb_wr && ready_q;
  assign last_pop = pop && ((rd_idx_q + IDX_ONE) == rsp_len_q);

  dobj_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
    .clk_i   (clk_i),
    .we_i    (wmb_ok),
    .waddr_i (wr_idx_q),
    .wdata_i (wdata_i),
    .raddr_i (rd_idx_q),
    .rdata_o (buf_rdata)
  );

  dobj_responder #(.LAT(LAT), .IDX_W(IDX_W)) u_rsp (
    .clk_i   (clk_i),
    .rst_ni  (trst_n),
    .start_i (start),
    .kill_i  (abort),
    .count_i (wr_idx_q),
    .busy_o  (busy),
    .done_o  (done),
    .count_o (rsp_cnt)
  );

  dobj_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (done || err_set),
    .clr_i  (sts_wr && wdata_i[ST_INT]),
    .sts_o  (int_sts)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      int_en_q <= 1'b0;
    else if (wr_ctrl) int_en_q <= wdata_i[CTL_IEN];
  end

  always_ff @(posedge clk_i or negedge trst_n) begin
    if (!trst_n) begin
      wr_idx_q  <= '0;
      rd_idx_q  <= '0;
      rsp_len_q <= '0;
      hdr_len_q <= '0;
      ready_q   <= 1'b0;
      err_q     <= 1'b0;
    end else if (abort) begin
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      ready_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (err_hit) err_q <= 1'b1;
      if (start) wr_idx_q <= '0;
      else if (wmb_ok) begin
        wr_idx_q <= wr_idx_q + IDX_ONE;
        if (wr_idx_q == IDX_ONE) hdr_len_q <= wdata_i[LEN_W-1:0];
      end
      if (done) begin
        ready_q   <= 1'b1;
        rd_idx_q  <= '0;
        rsp_len_q <= rsp_cnt;
      end else if (last_pop) begin
        ready_q  <= 1'b0;
        rd_idx_q <= '0;
      end else if (pop) begin
        rd_idx_q <= rd_idx_q + IDX_ONE;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: rdata_o[CTL_IEN] = int_en_q;
      A_STS: begin
        rdata_o[ST_BUSY] = busy;
        rdata_o[ST_INT]  = int_sts;
        rdata_o[ST_ERR]  = err_q;
        rdata_o[ST_RDY]  = ready_q;
      end
      A_RMB:   rdata_o = ready_q ? buf_rdata : '0;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = int_sts && int_en_q;
endmodule

// File: rtl/dobj_mailbox_chk.sv
module dobj_mailbox_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  addr_i,
  input logic        we_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        irq_o,
  input logic        busy,
  input logic        ready_q,
  input logic        err_q,
  input logic        int_sts,
  input logic        int_en_q
);
  logic abort_wr;
  assign abort_wr = we_i && (addr_i == 2'd0) && wdata_i[0];

  AST_BUSY_RDY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy && ready_q)); // R2

  AST_RDY_RAISES_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_q) |-> int_sts); // R8

  AST_INT_FALL_BY_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_sts) |-> $past(we_i && (addr_i == 2'd1) && wdata_i[1])); // R8

  AST_ABORT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_wr |=> (!busy && !ready_q && !err_q)); // R10

  AST_ABORT_KEEPS_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_wr && int_sts) |=> int_sts); // R10

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_q && (addr_i == 2'd3)) |-> (rdata_o == 32'd0)); // R4

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (int_en_q && int_sts)); // R9
endmodule

bind dobj_mailbox dobj_mailbox_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .busy     (busy),
  .ready_q  (ready_q),
  .err_q    (err_q),
  .int_sts  (int_sts),
  .int_en_q (int_en_q)
);

// File: tb/sim_dobj_mailbox.sv
module sim_dobj_mailbox;
  localparam int DEPTH = 16;
  localparam int LAT   = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frst_n = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] obj [0:63];
  logic [31:0] rv;
  int ien = 0;

  always #10 clk = ~clk;

  dobj_mailbox #(.DEPTH(DEPTH), .LAT(LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .func_rst_ni(frst_n), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] stv(bit b, bit i, bit e, bit r);
    return {r, 28'd0, e, i, b};
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(logic [1:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic mk_obj(int n);
    logic [31:0] t;
    obj[0] = $urandom;
    t = $urandom;
    obj[1] = {t[31:16], 16'(n)};
    for (int k = 2; k < n; k++) obj[k] = $urandom;
  endtask

  task automatic send(int n);
    for (int k = 0; k < n; k++) wr(2'd2, obj[k]);
  endtask

  task automatic go();
    wr(2'd0, 32'h8000_0000 | (32'(ien) << 1));
  endtask

  task automatic abort();
    wr(2'd0, 32'h1 | (32'(ien) << 1));
  endtask

  task automatic wait_done(string req);
    for (int k = 0; k < 50; k++) begin
      rd(2'd1, rv);
      if (!rv[0]) break;
      @(negedge clk);
    end
    chk(req, {31'd0, rv[31]}, 32'd1);
  endtask

  task automatic read_obj(string req, int n);
    for (int k = 0; k < n; k++) begin
      rd(2'd3, rv);
      chk(req, rv, obj[k]);
      wr(2'd3, 32'd0);
    end
    rd(2'd1, rv);
    chk(req, {31'd0, rv[31]}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd1, rv); chk("R1 status", rv, 32'd0);
    rd(2'd0, rv); chk("R1 ctrl", rv, 32'd0);
    rd(2'd3, rv); chk("R1 rmb", rv, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 exact busy window, R3 ordered readout
    mk_obj(3); send(3); go();
    rd(2'd1, rv); chk("R2 busy set", rv, stv(1, 0, 0, 0));
    repeat (LAT - 1) @(negedge clk);
    rd(2'd1, rv); chk("R2 busy last cycle", rv, stv(1, 0, 0, 0));
    @(negedge clk);
    rd(2'd1, rv); chk("R2 done R8 int", rv, stv(0, 1, 0, 1));
    chk("R9 irq gated off", {31'd0, irq}, 32'd0);
    read_obj("R3", 3);

    // R4 empty read and ignored pop
    rd(2'd3, rv); chk("R4 empty read", rv, 32'd0);
    wr(2'd3, 32'd0); wr(2'd3, 32'd0);
    mk_obj(2); send(2); go(); wait_done("R4 done");
    read_obj("R4 index kept", 2);

    // R8 write-1-to-clear
    wr(2'd1, 32'h8000_0005);
    rd(2'd1, rv); chk("R8 zero bit no clear", rv[1] ? 32'd1 : 32'd0, 32'd1);
    wr(2'd1, 32'h2);
    rd(2'd1, rv); chk("R8 w1c", rv, 32'd0);

    // R9 enable, R7 go with empty buffer
    ien = 1; wr(2'd0, 32'h2);
    rd(2'd0, rv); chk("R9 ctrl readback", rv, 32'h2);
    go();
    rd(2'd1, rv); chk("R7 go empty", rv, stv(0, 1, 1, 0));
    chk("R9 irq", {31'd0, irq}, 32'd1);

    // R10 abort keeps int status
    abort();
    rd(2'd1, rv); chk("R10 abort keeps int", rv, stv(0, 1, 0, 0));
    chk("R10 irq kept", {31'd0, irq}, 32'd1);
    wr(2'd1, 32'h2);
    ien = 0; wr(2'd0, 32'h0);

    // R5 header overflow: 4th dword dropped
    mk_obj(3); obj[3] = 32'hDEAD_BEEF; send(4);
    rd(2'd1, rv); chk("R5 hdr overflow", rv, stv(0, 1, 1, 0));
    go(); wait_done("R5 done");
    read_obj("R5 echo", 3);
    abort(); wr(2'd1, 32'h2);

    // R5 depth overflow
    mk_obj(DEPTH); obj[1][15:0] = 16'hFFFF;
    send(DEPTH);
    rd(2'd1, rv); chk("R5 full no err", rv, 32'd0);
    wr(2'd2, 32'h1234_5678);
    rd(2'd1, rv); chk("R5 depth overflow", rv, stv(0, 1, 1, 0));
    go(); wait_done("R5 depth done");
    read_obj("R5 depth echo", DEPTH);
    abort(); wr(2'd1, 32'h2);

    // R6 / R7 traffic while busy
    mk_obj(2); send(2); go();
    wr(2'd2, 32'hAAAA_5555);
    rd(2'd1, rv); chk("R6 wmb while busy", rv, stv(1, 1, 1, 0));
    go();
    rd(2'd1, rv); chk("R7 go while busy", {31'd0, rv[0]}, 32'd1);
    wait_done("R6 done");
    read_obj("R6 intact", 2);
    abort(); wr(2'd1, 32'h2);

    // R10 abort mid-read
    mk_obj(5); send(5); go(); wait_done("R10 done");
    rd(2'd3, rv); chk("R10 first", rv, obj[0]);
    wr(2'd3, 32'd0);
    abort();
    rd(2'd1, rv); chk("R10 abort status", rv, stv(0, 1, 0, 0));
    rd(2'd3, rv); chk("R10 rmb zero", rv, 32'd0);
    wr(2'd1, 32'h2);

    // R11 function reset mid-read
    ien = 1; wr(2'd0, 32'h2);
    mk_obj(4); send(4); go(); wait_done("R11 done");
    wr(2'd3, 32'd0);
    #2 frst_n = 1'b0;
    #2 frst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, rv); chk("R11 status", rv, stv(0, 1, 0, 0));
    rd(2'd0, rv); chk("R11 ien kept", rv, 32'h2);
    chk("R11 irq", {31'd0, irq}, 32'd1);
    mk_obj(3); send(3); go(); wait_done("R11 after");
    read_obj("R11 fresh", 3);
    wr(2'd1, 32'h2);
    ien = 0; wr(2'd0, 32'h0);

    // R10 abort beats go, write index reset
    mk_obj(2); send(2);
    wr(2'd0, 32'h8000_0001);
    rd(2'd1, rv); chk("R10 abort over go", rv, 32'd0);
    go();
    rd(2'd1, rv); chk("R10 index reset", rv, stv(0, 1, 1, 0));
    abort(); wr(2'd1, 32'h2);

    // random objects with random truncation
    for (int it = 0; it < 40; it++) begin
      int n = 2 + int'($urandom % (DEPTH - 1));
      int mode = int'($urandom % 3);
      int cut = int'($urandom % n);
      mk_obj(n); send(n); go(); wait_done("R2 rand");
      if (mode == 0) read_obj("R3 rand", n);
      else begin
        for (int k = 0; k < cut; k++) begin
          rd(2'd3, rv); chk("R3 rand part", rv, obj[k]);
          wr(2'd3, 32'd0);
        end
        if (mode == 1) abort();
        else begin
          #2 frst_n = 1'b0;
          #2 frst_n = 1'b1;
          @(negedge clk);
        end
        rd(2'd3, rv); chk(mode == 1 ? "R10 rand cut" : "R11 rand cut", rv, 32'd0);
      end
      rd(2'd1, rv); chk("R8 rand int", rv, stv(0, 1, 0, 0));
      wr(2'd1, 32'h2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule